// File: doc/BRIEF.md
# Multiplexed Numeric Display Scanner

This block refreshes a fifteen-digit numeric display by lighting one digit at a time. A shared position counter picks the active digit. Each digit position has its own anode enable, and ten numeral lines are shared by all digits, one line for each numeral 0 to 9. Outside the block, the data path reads the counter value and puts the BCD digit for that position on the data bus. The block decodes that value to exactly one numeral line, so the lit anode and the numeral shown always match.

The same counter also serves the digit-serial arithmetic unit. While `calc_busy` is high, the refresh timer stops and the arithmetic unit takes over the counter through a load port and an increment port. The anodes keep following the counter during this time. Long multiply and divide runs therefore leave a visible ripple on the display instead of blanking it. The count range is 0 to 15 for refresh and 0 to 31 for arithmetic. A separate set/clear flag drives the negative-result lamp.

Top module: `digit_scan_top`

## Requirements
- R1: While reset is active and on the first cycle after it, `pos_out` is 0, every anode enable is low and `neg_lamp` is low.
- R2: With `calc_busy` low, the position holds for DWELL_CYC clock cycles and then steps by one. The step after 15 is 0.
- R3: `anode_en[i]` is high exactly when `pos_out` equals i+1. Position 0 and positions 16 to 31 enable no anode (blank slot). At most one anode is ever high.
- R4: `cathode_sel[k]` is high exactly when `digit_bcd` equals k, for k from 0 to 9. Codes 10 to 15 drive all cathode lines low.
- R5: With `calc_busy` high and `ext_load` high, `pos_out` takes `ext_load_val` at the next edge. The load wins over `ext_inc`.
- R6: With `calc_busy` high, `ext_inc` high and `ext_load` low, `pos_out` steps by one modulo 32 at the next edge, so 31 is followed by 0.
- R7: With `calc_busy` high and neither command present, `pos_out` holds.
- R8: When `calc_busy` falls, the position in force holds for a full DWELL_CYC cycles. Its next refresh step keeps the low four bits plus one and clears bit 4, so 20 steps to 5 and 31 steps to 0.
- R9: `neg_clr` drives `neg_lamp` low at the next edge and wins over `neg_set`. `neg_set` alone drives it high, and with neither input the lamp holds.
- R10: With `calc_busy` low, `ext_load` and `ext_inc` have no effect on `pos_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| calc_busy | input | 1 | Arithmetic unit owns the position counter |
| ext_load | input | 1 | Load counter from ext_load_val (busy only) |
| ext_load_val | input | CNT_W | Value to load |
| ext_inc | input | 1 | Increment counter (busy only) |
| digit_bcd | input | 4 | BCD digit on the bus for the current position |
| neg_set | input | 1 | Light the negative-result lamp |
| neg_clr | input | 1 | Extinguish the negative-result lamp |
| pos_out | output | CNT_W | Current shared position count |
| anode_en | output | NUM_DIGITS | One enable per digit position |
| cathode_sel | output | 10 | One-hot numeral line, bit k lights numeral k |
| neg_lamp | output | 1 | Negative-result indicator |

## Verification
The bench targets the boundaries of the counter. It checks the wrap from 31 to 0 under the increment port, and the return to refresh from positions 20 and 31. A design that kept bit 4 would blank the display forever, and one that let the counter carry into bit 4 would step 15 to 16. It checks that the load wins over a simultaneous increment, and that a refresh position keeps its full dwell after busy falls; a stale dwell count would cut the first digit short. It also drives BCD codes 10 to 15 and the blank counts 0 and 16 or more: a decoder that aliased these would light a wrong numeral or a spurious anode. Load and increment pulses applied while busy is low must leave the scan undisturbed.

// File: rtl/dscan_pkg.sv
package dscan_pkg;

    localparam int unsigned BCD_W    = 4;
    localparam int unsigned NUMERALS = 10;

    typedef logic [BCD_W-1:0]    bcd_t;
    typedef logic [NUMERALS-1:0] numeral_vec_t;

endpackage

// File: rtl/dscan_pos_counter.sv
module dscan_pos_counter #(
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned SCAN_W    = 4,
    parameter int unsigned DWELL_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] pos
);

    localparam int unsigned DW_W = (DWELL_CYC > 2) ? $clog2(DWELL_CYC) : 1;
    localparam logic [DW_W-1:0] DW_LAST = DW_W'(DWELL_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DW_W-1:0]  dwell;
    } pos_state_t;

    pos_state_t st_d, st_q;
    logic [CNT_W-1:0] scan_nx_d;

    // Refresh step: the low scan bits wrap, the calculation-only bits are cleared.
    always_comb begin
        scan_nx_d = '0;
        scan_nx_d[SCAN_W-1:0] = st_q.cnt[SCAN_W-1:0] + SCAN_W'(1);
    end

    always_comb begin
        st_d = st_q;
        if (busy) begin
            st_d.dwell = '0;
            if (load) begin
                st_d.cnt = load_val;
            end else if (inc) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else if (st_q.dwell == DW_LAST) begin
            st_d.dwell = '0;
            st_d.cnt   = scan_nx_d;
        end else begin
            st_d.dwell = st_q.dwell + DW_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos = st_q.cnt;

endmodule

// File: rtl/dscan_anode_dec.sv
module dscan_anode_dec #(
    parameter int unsigned CNT_W      = 5,
    parameter int unsigned NUM_DIGITS = 15
) (
    input  logic [CNT_W-1:0]      pos,
    output logic [NUM_DIGITS-1:0] anode
);

    // Slot 0 and every count above NUM_DIGITS match no digit and blank.
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_anode
        localparam logic [CNT_W-1:0] MATCH = CNT_W'(g + 1);
        assign anode[g] = &(~(pos ^ MATCH));
    end

endmodule

// File: rtl/dscan_cathode_dec.sv
module dscan_cathode_dec
    import dscan_pkg::*;
(
    input  bcd_t         bcd,
    output numeral_vec_t numeral
);

    // Codes above nine match no numeral line.
    for (genvar k = 0; k < NUMERALS; k++) begin : g_numeral
        assign numeral[k] = (bcd == BCD_W'(k));
    end

endmodule

// File: rtl/digit_scan_top.sv
module digit_scan_top
    import dscan_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 15,
    parameter int unsigned CNT_W      = 5,
    parameter int unsigned SCAN_W     = 4,
    parameter int unsigned DWELL_CYC  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  calc_busy,
    input  logic                  ext_load,
    input  logic [CNT_W-1:0]      ext_load_val,
    input  logic                  ext_inc,
    input  logic [3:0]            digit_bcd,
    input  logic                  neg_set,
    input  logic                  neg_clr,
    output logic [CNT_W-1:0]      pos_out,
    output logic [NUM_DIGITS-1:0] anode_en,
    output logic [9:0]            cathode_sel,
    output logic                  neg_lamp
);

    typedef struct packed {
        logic neg;
    } flag_state_t;

    flag_state_t fl_d, fl_q;

    dscan_pos_counter #(
        .CNT_W    (CNT_W),
        .SCAN_W   (SCAN_W),
        .DWELL_CYC(DWELL_CYC)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (calc_busy),
        .load    (ext_load),
        .load_val(ext_load_val),
        .inc     (ext_inc),
        .pos     (pos_out)
    );

    dscan_anode_dec #(
        .CNT_W     (CNT_W),
        .NUM_DIGITS(NUM_DIGITS)
    ) u_anode (
        .pos  (pos_out),
        .anode(anode_en)
    );

    dscan_cathode_dec u_cath (
        .bcd    (digit_bcd),
        .numeral(cathode_sel)
    );

    always_comb begin
        fl_d = fl_q;
        if (neg_clr) begin
            fl_d.neg = 1'b0;
        end else if (neg_set) begin
            fl_d.neg = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign neg_lamp = fl_q.neg;

endmodule

// File: rtl/dscan_chk.sv
module dscan_chk #(
    parameter int unsigned NUM_DIGITS = 15,
    parameter int unsigned CNT_W      = 5,
    parameter int unsigned SCAN_W     = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  calc_busy,
    input logic                  ext_load,
    input logic [CNT_W-1:0]      ext_load_val,
    input logic                  ext_inc,
    input logic [3:0]            digit_bcd,
    input logic                  neg_set,
    input logic                  neg_clr,
    input logic [CNT_W-1:0]      pos_out,
    input logic [NUM_DIGITS-1:0] anode_en,
    input logic [9:0]            cathode_sel,
    input logic                  neg_lamp
);

    logic [CNT_W-1:0] refresh_step;
    always_comb begin
        refresh_step = '0;
        refresh_step[SCAN_W-1:0] = pos_out[SCAN_W-1:0] + SCAN_W'(1);
    end

    p_reset_pos_r1: assert property (@(posedge clk)
        !rst_n |=> (pos_out == '0) && !neg_lamp);

    p_one_anode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(anode_en));

    p_anode_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_out >= CNT_W'(1)) && (32'(pos_out) <= NUM_DIGITS)
        |-> anode_en[pos_out - CNT_W'(1)]);

    p_blank_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pos_out == '0) || (32'(pos_out) > NUM_DIGITS)) |-> (anode_en == '0));

    p_cathode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_bcd <= 4'd9) |-> ($countones(cathode_sel) == 1) && cathode_sel[digit_bcd]);

    p_cathode_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (digit_bcd > 4'd9) |-> (cathode_sel == '0));

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        calc_busy && ext_load |=> pos_out == $past(ext_load_val));

    p_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        calc_busy && !ext_load && ext_inc |=> pos_out == $past(pos_out) + CNT_W'(1));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        calc_busy && !ext_load && !ext_inc |=> $stable(pos_out));

    p_idle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !calc_busy |=> (pos_out == $past(pos_out)) || (pos_out == $past(refresh_step)));

    p_neg_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        neg_clr |=> !neg_lamp);

    p_neg_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        neg_set && !neg_clr |=> neg_lamp);

    p_neg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !neg_set && !neg_clr |=> $stable(neg_lamp));

endmodule

bind digit_scan_top dscan_chk #(
    .NUM_DIGITS(NUM_DIGITS),
    .CNT_W     (CNT_W),
    .SCAN_W    (SCAN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .calc_busy   (calc_busy),
    .ext_load    (ext_load),
    .ext_load_val(ext_load_val),
    .ext_inc     (ext_inc),
    .digit_bcd   (digit_bcd),
    .neg_set     (neg_set),
    .neg_clr     (neg_clr),
    .pos_out     (pos_out),
    .anode_en    (anode_en),
    .cathode_sel (cathode_sel),
    .neg_lamp    (neg_lamp)
);

// File: tb/sim_digit_scan_top.sv
module sim_digit_scan_top;

    localparam int CLK_PERIOD = 40;
    localparam int ND   = 15;
    localparam int CW   = 5;
    localparam int DWEL = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          calc_busy, ext_load, ext_inc, neg_set, neg_clr;
    logic [CW-1:0] ext_load_val;
    logic [3:0]    digit_bcd;
    logic [CW-1:0] pos_out;
    logic [ND-1:0] anode_en;
    logic [9:0]    cathode_sel;
    logic          neg_lamp;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    digit_scan_top #(.NUM_DIGITS(ND), .CNT_W(CW), .SCAN_W(4), .DWELL_CYC(DWEL)) u0 (
        .clk(clk), .rst_n(rst_n), .calc_busy(calc_busy), .ext_load(ext_load),
        .ext_load_val(ext_load_val), .ext_inc(ext_inc), .digit_bcd(digit_bcd),
        .neg_set(neg_set), .neg_clr(neg_clr), .pos_out(pos_out),
        .anode_en(anode_en), .cathode_sel(cathode_sel), .neg_lamp(neg_lamp)
    );

    // Row fields: {load, inc, load_val[4:0], bcd[3:0], expected pos[4:0]}
    localparam int NROW = 16;
    localparam logic [15:0] VEC [NROW] = '{
        {1'b1, 1'b0, 5'd3,  4'd0,  5'd3},   // R5 load
        {1'b0, 1'b1, 5'd0,  4'd1,  5'd4},   // R6
        {1'b0, 1'b1, 5'd0,  4'd2,  5'd5},   // R6
        {1'b0, 1'b0, 5'd0,  4'd3,  5'd5},   // R7 hold
        {1'b1, 1'b1, 5'd15, 4'd4,  5'd15},  // R5 load beats inc
        {1'b0, 1'b1, 5'd0,  4'd5,  5'd16},  // R6 into blank range
        {1'b1, 1'b0, 5'd31, 4'd6,  5'd31},  // R5
        {1'b0, 1'b1, 5'd0,  4'd7,  5'd0},   // R6 wrap 31 -> 0
        {1'b0, 1'b1, 5'd0,  4'd8,  5'd1},   // R6
        {1'b0, 1'b0, 5'd0,  4'd9,  5'd1},   // R7
        {1'b1, 1'b0, 5'd0,  4'd10, 5'd0},   // R5, R4 code 10
        {1'b1, 1'b0, 5'd14, 4'd11, 5'd14},  // R5
        {1'b0, 1'b1, 5'd0,  4'd12, 5'd15},  // R6 last digit
        {1'b0, 1'b0, 5'd0,  4'd13, 5'd15},  // R7
        {1'b1, 1'b0, 5'd9,  4'd14, 5'd9},   // R5
        {1'b0, 1'b1, 5'd0,  4'd15, 5'd10}   // R6, R4 code 15
    };

    function automatic logic [ND-1:0] exp_anode(input int p);
        if (p >= 1 && p <= ND) return ND'(1) << (p - 1);
        return '0;
    endfunction

    function automatic logic [9:0] exp_cath(input int b);
        if (b <= 9) return 10'(1) << b;
        return '0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_pos(input string req, input int p);
        chk(req, 32'(pos_out), 32'(p));
        chk("R3", 32'(anode_en), 32'(exp_anode(p)));
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // Load a value under busy, then release busy and watch the first refresh step.
    task automatic release_from(input int start, input int nxt);
        calc_busy = 1'b1; ext_load = 1'b1; ext_load_val = CW'(start);
        step(1);
        ext_load = 1'b0;
        chk_pos("R5", start);
        calc_busy = 1'b0;
        step(DWEL - 1);
        chk_pos("R8", start);
        step(1);
        chk_pos("R8", nxt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; calc_busy = 1'b0; ext_load = 1'b0; ext_inc = 1'b0;
        ext_load_val = '0; digit_bcd = 4'd0; neg_set = 1'b0; neg_clr = 1'b0;
        step(3);
        chk_pos("R1", 0);
        chk("R1", 32'(neg_lamp), 0);
        rst_n = 1'b1;
        step(1);
        chk_pos("R1", 0);
        chk("R1", 32'(neg_lamp), 0);

        // Busy-mode table walk
        calc_busy = 1'b1;
        for (int r = 0; r < NROW; r++) begin
            ext_load     = VEC[r][15];
            ext_inc      = VEC[r][14];
            ext_load_val = VEC[r][13:9];
            digit_bcd    = VEC[r][8:5];
            step(1);
            chk_pos("R5/R6/R7", int'(VEC[r][4:0]));
            chk("R4", 32'(cathode_sel), 32'(exp_cath(int'(VEC[r][8:5]))));
        end

        // Release at 10: full dwell, then refresh continues and wraps
        ext_load = 1'b0; ext_inc = 1'b0; calc_busy = 1'b0;
        step(DWEL - 1);
        chk_pos("R8", 10);
        step(1);
        chk_pos("R2", 11);
        for (int p = 12; p <= 16; p++) begin
            step(DWEL);
            chk_pos("R2", p % 16);
        end

        // Commands ignored while idle (now at position 0, start of dwell)
        ext_load = 1'b1; ext_inc = 1'b1; ext_load_val = 5'd7;
        step(DWEL - 1);
        chk_pos("R10", 0);
        step(1);
        chk_pos("R10", 1);
        ext_load = 1'b0; ext_inc = 1'b0;

        // Return to refresh from the calculation-only range
        release_from(20, 5);
        release_from(31, 0);
        release_from(15, 0);

        // Negative lamp
        neg_set = 1'b1; step(1);
        chk("R9", 32'(neg_lamp), 1);
        neg_set = 1'b0; step(2);
        chk("R9", 32'(neg_lamp), 1);
        neg_set = 1'b1; neg_clr = 1'b1; step(1);
        chk("R9", 32'(neg_lamp), 0);
        neg_clr = 1'b0; step(1);
        chk("R9", 32'(neg_lamp), 1);
        neg_set = 1'b0; neg_clr = 1'b1; step(1);
        chk("R9", 32'(neg_lamp), 0);
        neg_clr = 1'b0; neg_set = 1'b1; step(1);
        neg_set = 1'b0;

        // Reset in mid-run
        calc_busy = 1'b1; ext_load = 1'b1; ext_load_val = 5'd6; step(1);
        ext_load = 1'b0;
        rst_n = 1'b0; step(1);
        chk_pos("R1", 0);
        chk("R1", 32'(neg_lamp), 0);
        rst_n = 1'b1; calc_busy = 1'b0;
        step(1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule